// File: doc/BRIEF.md
# Shift Register with Storage Loop

This block pairs a serial shift register with a storage register of the same width, and joins the two in a two-way parallel loop. Serial data enters and leaves through one bidirectional three-state pin. In write mode an outside driver supplies a bit that shifts into the low end. In read mode the block drives the top shift bit onto the pin and recirculates it into bit 0, so the word survives being read. A store strobe copies the whole shift word into the storage register, whose value appears on the parallel outputs. A load command copies the storage word back into the shift register.

The shift and store clocks are modelled as level inputs sampled by one system clock. Each of them is ANDed with chip select and acts on the rising edge of the gated level. Deselecting the block blocks both clocks and releases the pin. The storage clear is asynchronous and active low, and it works whether or not the block is selected.

Top module: `shift_store_loop`

## Requirements
- R1: After system reset both registers hold zero, and while chip select is high the block does not drive the serial pin.
- R2: In read mode (rw=1, load=0), each shift edge moves every bit one place toward the MSB and copies the old MSB into bit 0.
- R3: In write mode (rw=0, load=0), each shift edge moves every bit one place toward the MSB and places the serial pin's value in bit 0.
- R4: A shift edge with load=1 copies the storage word into the shift register, whatever the value of rw.
- R5: A store edge copies the shift word into the storage register. The value copied is the one held before any shift edge in the same cycle.
- R6: While cs_n is high, shift and store clock activity changes neither register.
- R7: The block drives the shift MSB onto the serial pin only when cs_n=0 and rw=1. At all other times the pin carries the external driver's value.
- R8: clr_n low zeroes the storage register at once, without waiting for a clock. It works even when the block is deselected, it wins over a store edge, and it leaves the shift register unchanged.
- R9: A clock input counts once on each rising edge of its level. Holding the level high does not produce further shifts.
- R10: An edge is the rise of (clock level AND selected). A shift clock that is already high when cs_n falls therefore gives one shift. For this reason cs_n may rise only while the shift clock is low, and may fall only while the store clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read (rotate, drive pin), 0 = write (shift in from pin) |
| load | input | 1 | 1 = a shift edge loads the storage word in parallel |
| shift_clk | input | 1 | Shift clock level |
| store_clk | input | 1 | Store clock level |
| clr_n | input | 1 | Asynchronous active-low clear of the storage register |
| sdio | inout | 1 | Three-state serial data pin |
| par_q | output | WIDTH | Storage register contents |

## Verification
The bench builds the block with WIDTH=16 and SYNC_STAGES=2. At that width, a full 16-bit pattern can be written serially and then rotated several places within a few hundred cycles. Rotations that wrap past the MSB, a load that replaces a freshly written word, and same-cycle shift and store edges can all be observed through the parallel outputs. The two-stage reset synchronizer keeps the idle period after reset short. A cycle-level model also follows the pin state while it passes between the block and the bench.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  typedef enum logic [1:0] {
    SH_HOLD   = 2'd0,
    SH_ROTATE = 2'd1,
    SH_SERIAL = 2'd2,
    SH_LOAD   = 2'd3
  } sh_op_e;
endpackage

// File: rtl/ssl_gated_edge.sv
module ssl_gated_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic enable,
  output logic rise
);
  logic gated;
  logic prev_q;
  logic prev_d;

  always_comb begin
    gated  = lvl & enable;
    prev_d = gated;
    rise   = gated & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/ssl_shift_reg.sv
module ssl_shift_reg
  import ssl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sh_op_e           op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] word
);
  logic [WIDTH-1:0] word_d;

  always_comb begin
    unique case (op)
      SH_ROTATE: word_d = {word[WIDTH-2:0], word[WIDTH-1]};
      SH_SERIAL: word_d = {word[WIDTH-2:0], ser_in};
      SH_LOAD:   word_d = par_in;
      default:   word_d = word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_d;
  end
endmodule

// File: rtl/ssl_store_reg.sv
module ssl_store_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = capture ? d : q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end
endmodule

// File: rtl/shift_store_loop.sv
module shift_store_loop
  import ssl_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             load,
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clr_n,
  inout  wire              sdio,
  output logic [WIDTH-1:0] par_q
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SMSB:0]    rst_sync_q;
  logic             rstn_i;
  logic             store_arst_n;
  logic             selected;
  logic             sh_rise;
  logic             st_rise;
  logic             drv_en;
  logic             ser_in;
  sh_op_e           sh_op;
  logic [WIDTH-1:0] shift_word;

  // reset: asserted asynchronously, released after SYNC_STAGES clocks
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SMSB-1:0], 1'b1};
      end
    end else begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end
  endgenerate

  always_comb begin
    rstn_i       = rst_sync_q[SMSB];
    store_arst_n = rstn_i & clr_n;
    selected     = ~cs_n;
    drv_en       = selected & rw;
    ser_in       = sdio;
    if (!sh_rise)   sh_op = SH_HOLD;
    else if (load)  sh_op = SH_LOAD;
    else if (rw)    sh_op = SH_ROTATE;
    else            sh_op = SH_SERIAL;
  end

  assign sdio = drv_en ? shift_word[WIDTH-1] : 1'bz;

  ssl_gated_edge u_sh_edge (
    .clk(clk), .rst_n(rstn_i), .lvl(shift_clk), .enable(selected), .rise(sh_rise)
  );

  ssl_gated_edge u_st_edge (
    .clk(clk), .rst_n(rstn_i), .lvl(store_clk), .enable(selected), .rise(st_rise)
  );

  ssl_shift_reg #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rstn_i), .op(sh_op), .ser_in(ser_in),
    .par_in(par_q), .word(shift_word)
  );

  ssl_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .arst_n(store_arst_n), .capture(st_rise),
    .d(shift_word), .q(par_q)
  );
endmodule

// File: rtl/ssl_chk.sv
module ssl_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rw,
  input logic             load,
  input logic             shift_clk,
  input logic             store_clk,
  input logic             clr_n,
  input logic             sh_rise,
  input logic             st_rise,
  input logic [WIDTH-1:0] shift_word,
  input logic [WIDTH-1:0] par_q
);
  // R10
  cs_rise_shclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !shift_clk);

  // R10
  cs_fall_stclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !store_clk);

  // R6
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(shift_word));

  // R2
  rotate_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rise && rw && !load) |=> shift_word[0] == $past(shift_word[WIDTH-1]));

  // R3
  serial_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rise && !rw && !load) |=> shift_word[WIDTH-1:1] == $past(shift_word[WIDTH-2:0]));

  // R5
  store_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rise && clr_n) |=> (par_q == $past(shift_word)) || !clr_n);

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> par_q == '0);
endmodule

bind shift_store_loop ssl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .load(load),
  .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
  .sh_rise(sh_rise), .st_rise(st_rise), .shift_word(shift_word), .par_q(par_q)
);

// File: tb/sim_shift_store_loop.sv
`timescale 1ns/1ps
module sim_shift_store_loop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rw = 1'b0;
  logic        load = 1'b0;
  logic        shift_clk = 1'b0;
  logic        store_clk = 1'b0;
  logic        clr_n = 1'b1;
  logic        tb_dat = 1'b0;
  logic        tb_oe;
  wire         sdio;
  logic [15:0] par_q;

  int compared = 0;
  int mismatched = 0;
  bit live = 0;
  bit done = 0;

  logic [15:0] m_sh, m_st;
  logic        m_psh, m_pst;
  logic [15:0] w;

  always #5 clk = ~clk;

  assign tb_oe = !(!cs_n && rw);
  assign sdio  = tb_oe ? tb_dat : 1'bz;

  shift_store_loop #(.WIDTH(16), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .load(load),
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
    .sdio(sdio), .par_q(par_q)
  );

  function automatic logic [15:0] rotl(input logic [15:0] v, input int n);
    logic [15:0] r = v;
    for (int i = 0; i < n; i++) r = {r[14:0], r[15]};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    logic gs, gt, er, et;
    logic [15:0] old_sh;
    if (!rst_n) begin
      m_sh = 16'h0; m_st = 16'h0; m_psh = 1'b0; m_pst = 1'b0;
    end else begin
      gs = shift_clk && !cs_n;
      gt = store_clk && !cs_n;
      er = gs && !m_psh;
      et = gt && !m_pst;
      m_psh = gs; m_pst = gt;
      old_sh = m_sh;
      if (er) begin
        if (load)     m_sh = m_st;
        else if (rw)  m_sh = {m_sh[14:0], m_sh[15]};
        else          m_sh = {m_sh[14:0], tb_dat};
      end
      if (!clr_n)     m_st = 16'h0;
      else if (et)    m_st = old_sh;
    end
  end

  // compared on every falling edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk("R5 storage vs model", par_q, m_st);
      if (!cs_n && rw) chk("R7 pin drives MSB", {15'h0, sdio}, {15'h0, m_sh[15]});
      else             chk("R7 pin released", {15'h0, sdio}, {15'h0, tb_dat});
    end
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic shift_pulse(); shift_clk = 1'b1; step(); shift_clk = 1'b0; step(); endtask
  task automatic store_pulse(); store_clk = 1'b1; step(); store_clk = 1'b0; step(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(50000 * 10);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();
    live = 1;

    // R1
    chk("R1 storage after reset", par_q, 16'h0);
    tb_dat = 1'b1; #1;
    chk("R1 pin undriven (1)", {15'h0, sdio}, 16'h1);
    tb_dat = 1'b0; #1;
    chk("R1 pin undriven (0)", {15'h0, sdio}, 16'h0);

    // R3 serial write of a pattern, MSB first
    cs_n = 1'b0; rw = 1'b0; step();
    w = 16'hA5C3;
    for (int i = 15; i >= 0; i--) begin
      tb_dat = w[i];
      shift_pulse();
    end
    store_pulse();
    chk("R3 serial word captured", par_q, w);

    // R7 read mode drives MSB; R2 rotate
    rw = 1'b1; step();
    chk("R7 pin shows MSB", {15'h0, sdio}, {15'h0, w[15]});
    for (int i = 0; i < 4; i++) shift_pulse();
    store_pulse();
    w = rotl(w, 4);
    chk("R2 rotate by four", par_q, w);

    // R9 level held high shifts once
    shift_clk = 1'b1; repeat (3) step();
    shift_clk = 1'b0; step();
    store_pulse();
    w = rotl(w, 1);
    chk("R9 single shift per edge", par_q, w);

    // R6 deselected clocks ignored
    cs_n = 1'b1; step();
    shift_pulse(); shift_pulse(); store_pulse();
    chk("R6 storage kept deselected", par_q, w);

    // R8 async clear while deselected
    clr_n = 1'b0; #1;
    chk("R8 async clear", par_q, 16'h0);
    step(); step();
    clr_n = 1'b1; step();
    cs_n = 1'b0; step();
    store_pulse();
    chk("R8 shift kept over clear", par_q, w);

    // R4 parallel load replaces a freshly written word
    rw = 1'b0; step();
    for (int i = 15; i >= 0; i--) begin
      tb_dat = (16'h1234 >> i) & 1;
      shift_pulse();
    end
    load = 1'b1; step();
    shift_pulse();
    load = 1'b0; rw = 1'b1; step();
    shift_pulse();
    store_pulse();
    w = rotl(w, 1);
    chk("R4 load then rotate", par_q, w);

    // R5 same-cycle shift and store take pre-shift value
    shift_clk = 1'b1; store_clk = 1'b1; step();
    shift_clk = 1'b0; store_clk = 1'b0; step();
    chk("R5 pre-shift capture", par_q, w);
    store_pulse();
    w = rotl(w, 1);
    chk("R5 post-shift capture", par_q, w);

    // R10 shift clock high when selection begins
    cs_n = 1'b1; step();
    shift_clk = 1'b1; step();
    cs_n = 1'b0; step();
    shift_clk = 1'b0; step();
    store_pulse();
    w = rotl(w, 1);
    chk("R10 select edge clocks shift", par_q, w);

    // R8 clear wins over a store edge
    clr_n = 1'b0; step();
    store_clk = 1'b1; step();
    store_clk = 1'b0; step();
    chk("R8 clear beats store", par_q, 16'h0);
    clr_n = 1'b1; step();
    chk("R8 stays clear", par_q, 16'h0);

    step();
    finish_run();
  end
endmodule